// File: doc/BRIEF.md
# Breakpoint VMID and Context Comparator

This block keeps the 32-bit extension word of one hardware breakpoint. Each cycle it decides whether that word matches the current execution context, and it registers the answer. The breakpoint type, which comes from a paired control register, sets what the word means. Type `10xx` makes the low bits a virtual machine identifier, compared over 8 or 16 bits. Type `11xx` makes the whole word a hypervisor-level context identifier. Any other type makes the word reserved and unable to match. A chip instantiates the block once per breakpoint, for up to sixteen breakpoints.

Software writes the word through a single-cycle write port. On each write the block clears the bits that are reserved under the type and feature flags applied in that same cycle, so a read always returns the masked value. Address comparison, breakpoint linking and exception generation belong to other blocks.

Top module: `bkpt_ctx_cmp`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears the stored word to zero and drives match_o low.
- R2: A write under type `10xx` with the hypervisor level present, and without 16-bit VMID mode, stores wr_data[7:0] in bits [7:0] and zero in bits [31:8]. 16-bit VMID mode means vmid16_supported and vmid_wide_sel are both 1.
- R3: A write under type `10xx` with the hypervisor level present and 16-bit VMID mode on stores wr_data[15:0] in bits [15:0] and zero in bits [31:16].
- R4: A write under type `11xx` with the hypervisor level present and at least one of feat_host_virt or feat_dbg_ext set stores all 32 bits of wr_data.
- R5: A write stores zero in every bit when the type is neither `10xx` nor `11xx`, when the type is `11xx` and both context feature flags are clear, or when el2_present is low.
- R6: Under type `10xx` without 16-bit VMID mode, match_o is 1 exactly when bits [7:0] of the stored word equal cur_vmid[7:0]. cur_vmid[15:8] has no effect.
- R7: Under type `10xx` with 16-bit VMID mode, match_o is 1 exactly when bits [15:0] of the stored word equal cur_vmid[15:0].
- R8: Under type `11xx` with a context feature flag set, match_o is 1 exactly when the stored word equals cur_ctx2. With both flags clear, match_o is 0.
- R9: match_o is 0 whenever el2_present is low, and whenever the type is neither `10xx` nor `11xx`.
- R10: match_o shows, one clock edge later, the comparison of the inputs applied in a cycle against the word held before that cycle's write. A write takes part in matching from the following cycle on.
- R11: In a cycle without a write, the stored word (rd_data) does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bp_type | input | 4 | Breakpoint type from the paired control register |
| el2_present | input | 1 | Hypervisor exception level implemented |
| vmid16_supported | input | 1 | 16-bit VMID support present |
| vmid_wide_sel | input | 1 | VMID-size control bit: 1 selects a 16-bit VMID |
| feat_host_virt | input | 1 | Host-virtualisation feature present |
| feat_dbg_ext | input | 1 | Later debug feature present |
| wr_en | input | 1 | Write strobe for the extension word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Stored, masked extension word |
| cur_vmid | input | 16 | Current virtual machine identifier |
| cur_ctx2 | input | 32 | Current hypervisor-level context identifier |
| match_o | output | 1 | Registered match flag |

## Verification
A register write and a match evaluation can occur in the same cycle. The comparator must then judge the cycle's context against the old word, while the new word lands in storage. The bench provokes this with a write whose data would match the current VMID while the old word does not. It expects match_o low after that edge and high after the next, with rd_data already holding the new value after the first edge. The scoreboard model keeps the same old-word-then-new-word order, so any forwarding of write data into the compare is flagged.

// File: rtl/bkpt_ctx_pkg.sv
// Package: shared types and helpers for the breakpoint context comparator.
// Assumes the breakpoint type is 4 bits with its upper two bits selecting
// the interpretation of the extension word.
package bkpt_ctx_pkg;

    localparam int TYPE_W = 4;

    typedef enum logic [1:0] {
        BK_OTHER = 2'd0,
        BK_VMID  = 2'd1,
        BK_CTX   = 2'd2
    } bk_kind_e;

    // Decode a breakpoint type into the word interpretation it selects.
    function automatic bk_kind_e classify(input logic [TYPE_W-1:0] t);
        bk_kind_e k;
        casez (t)
            4'b10??: k = BK_VMID;
            4'b11??: k = BK_CTX;
            default: k = BK_OTHER;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/bkpt_xvr_mask.sv
// Module: bkpt_xvr_mask
// Computes which bits of the extension word are live (not reserved) under
// the current type, feature flags and VMID size. Purely combinational.
// Assumes VMID_NARROW_W <= VMID_W <= WORD_W.
module bkpt_xvr_mask
    import bkpt_ctx_pkg::*;
#(
    parameter int WORD_W        = 32,
    parameter int VMID_W        = 16,
    parameter int VMID_NARROW_W = 8
) (
    input  bk_kind_e            kind,
    input  logic                el2_present,
    input  logic                vmid16_supported,
    input  logic                vmid_wide_sel,
    input  logic                feat_host_virt,
    input  logic                feat_dbg_ext,
    output logic                wide_vmid,
    output logic                ctx_enabled,
    output logic [WORD_W-1:0]   live_mask
);

    logic vmid_mode;
    logic ctx_mode;

    // Resolve the mode qualifiers shared by masking and matching.
    always_comb begin
        wide_vmid   = vmid16_supported & vmid_wide_sel;
        ctx_enabled = feat_host_virt | feat_dbg_ext;
        vmid_mode   = el2_present & (kind == BK_VMID);
        ctx_mode    = el2_present & (kind == BK_CTX) & ctx_enabled;
    end

    // Per-bit liveness, by which field each bit position belongs to.
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
        if (b < VMID_NARROW_W) begin : g_narrow
            assign live_mask[b] = vmid_mode | ctx_mode;
        end else if (b < VMID_W) begin : g_wide
            assign live_mask[b] = (vmid_mode & wide_vmid) | ctx_mode;
        end else begin : g_ctx
            assign live_mask[b] = ctx_mode;
        end
    end

endmodule

// File: rtl/bkpt_xvr_store.sv
// Module: bkpt_xvr_store
// Holds the extension word. A write stores the data ANDed with the live
// mask computed in the same cycle. Synchronous active-low reset to zero.
module bkpt_xvr_store #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] live_mask,
    output logic [WORD_W-1:0] word_q
);

    // Capture masked write data; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= wr_data & live_mask;
        end
    end

    // Reserved bits at write time must read back as zero (R2 R3 R5).
    assert_rsvd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((word_q & ~$past(live_mask)) == '0));

    // No write leaves the word untouched (R11).
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(word_q));

endmodule

// File: rtl/bkpt_ctx_match.sv
// Module: bkpt_ctx_match
// Compares the stored word with the current VMID or context identifier,
// per the decoded type, and registers the result. Assumes the word
// presented is the value held before any write in this cycle.
module bkpt_ctx_match
    import bkpt_ctx_pkg::*;
#(
    parameter int WORD_W        = 32,
    parameter int VMID_W        = 16,
    parameter int VMID_NARROW_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bk_kind_e          kind,
    input  logic              el2_present,
    input  logic              wide_vmid,
    input  logic              ctx_enabled,
    input  logic [WORD_W-1:0] word_q,
    input  logic [VMID_W-1:0] cur_vmid,
    input  logic [WORD_W-1:0] cur_ctx2,
    output logic              match_q
);

    logic vmid_lo_eq;
    logic vmid_hi_eq;
    logic ctx_eq;
    logic hit;

    // Field equality terms.
    always_comb begin
        vmid_lo_eq = (word_q[VMID_NARROW_W-1:0] == cur_vmid[VMID_NARROW_W-1:0]);
        vmid_hi_eq = (word_q[VMID_W-1:VMID_NARROW_W] == cur_vmid[VMID_W-1:VMID_NARROW_W]);
        ctx_eq     = (word_q == cur_ctx2);
    end

    // Select the comparison the type calls for.
    always_comb begin
        unique case (kind)
            BK_VMID: hit = vmid_lo_eq & (vmid_hi_eq | ~wide_vmid);
            BK_CTX:  hit = ctx_eq & ctx_enabled;
            default: hit = 1'b0;
        endcase
        hit = hit & el2_present;
    end

    // Register the match result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
        end else begin
            match_q <= hit;
        end
    end

    // Without the hypervisor level nothing matches (R9).
    assert_no_el2_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !el2_present |=> !match_q);

    // Narrow VMID mismatch in the low byte cannot match (R6).
    assert_narrow_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == BK_VMID && !wide_vmid &&
         word_q[VMID_NARROW_W-1:0] != cur_vmid[VMID_NARROW_W-1:0]) |=> !match_q);

    // Context type with no enabling feature cannot match (R8).
    assert_ctx_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == BK_CTX && !ctx_enabled) |=> !match_q);

    // Context match reflects previous-cycle equality (R10).
    assert_ctx_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == BK_CTX && ctx_enabled && el2_present && word_q == cur_ctx2) |=> match_q);

endmodule

// File: rtl/bkpt_ctx_cmp.sv
// Module: bkpt_ctx_cmp (top)
// One breakpoint's extension-word register plus its VMID / context
// comparator. Writes are masked by the mode in force that cycle; the match
// flag is registered and compares against the pre-write word.
module bkpt_ctx_cmp
    import bkpt_ctx_pkg::*;
#(
    parameter int WORD_W        = 32,
    parameter int VMID_W        = 16,
    parameter int VMID_NARROW_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TYPE_W-1:0]   bp_type,
    input  logic                el2_present,
    input  logic                vmid16_supported,
    input  logic                vmid_wide_sel,
    input  logic                feat_host_virt,
    input  logic                feat_dbg_ext,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   rd_data,
    input  logic [VMID_W-1:0]   cur_vmid,
    input  logic [WORD_W-1:0]   cur_ctx2,
    output logic                match_o
);

    bk_kind_e          kind;
    logic              wide_vmid;
    logic              ctx_enabled;
    logic [WORD_W-1:0] live_mask;
    logic [WORD_W-1:0] word_q;

    // Decode the breakpoint type once for both consumers.
    always_comb kind = classify(bp_type);

    bkpt_xvr_mask #(
        .WORD_W(WORD_W), .VMID_W(VMID_W), .VMID_NARROW_W(VMID_NARROW_W)
    ) u_mask (
        .kind(kind),
        .el2_present(el2_present),
        .vmid16_supported(vmid16_supported),
        .vmid_wide_sel(vmid_wide_sel),
        .feat_host_virt(feat_host_virt),
        .feat_dbg_ext(feat_dbg_ext),
        .wide_vmid(wide_vmid),
        .ctx_enabled(ctx_enabled),
        .live_mask(live_mask)
    );

    bkpt_xvr_store #(.WORD_W(WORD_W)) u_store (
        .clk(clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .wr_data(wr_data),
        .live_mask(live_mask),
        .word_q(word_q)
    );

    bkpt_ctx_match #(
        .WORD_W(WORD_W), .VMID_W(VMID_W), .VMID_NARROW_W(VMID_NARROW_W)
    ) u_match (
        .clk(clk),
        .rst_n(rst_n),
        .kind(kind),
        .el2_present(el2_present),
        .wide_vmid(wide_vmid),
        .ctx_enabled(ctx_enabled),
        .word_q(word_q),
        .cur_vmid(cur_vmid),
        .cur_ctx2(cur_ctx2),
        .match_q(match_o)
    );

    // Read path returns the stored, already-masked word.
    always_comb rd_data = word_q;

    // Types outside 1x never produce a match (R9).
    assert_other_type_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_type[3] |=> !match_o);

endmodule

// File: tb/bkpt_ctx_cmp_tb.sv
// Scoreboard bench: drive task computes expected results from the
// requirements and queues them; a monitor pops and compares after each edge.
module bkpt_ctx_cmp_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bp_type = 4'b0000;
    logic        el2_present = 1'b1;
    logic        vmid16_supported = 1'b0;
    logic        vmid_wide_sel = 1'b0;
    logic        feat_host_virt = 1'b0;
    logic        feat_dbg_ext = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [15:0] cur_vmid = '0;
    logic [31:0] cur_ctx2 = '0;
    logic        match_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] model_word = '0;

    typedef struct {
        logic        m;
        logic [31:0] rd;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    bkpt_ctx_cmp dut_i (
        .clk(clk), .rst_n(rst_n), .bp_type(bp_type), .el2_present(el2_present),
        .vmid16_supported(vmid16_supported), .vmid_wide_sel(vmid_wide_sel),
        .feat_host_virt(feat_host_virt), .feat_dbg_ext(feat_dbg_ext),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .cur_vmid(cur_vmid), .cur_ctx2(cur_ctx2), .match_o(match_o)
    );

    function automatic logic [31:0] req_mask();
        logic [31:0] m = '0;
        if (el2_present && bp_type[3:2] == 2'b10)
            m = (vmid16_supported && vmid_wide_sel) ? 32'h0000_FFFF : 32'h0000_00FF;
        else if (el2_present && bp_type[3:2] == 2'b11 && (feat_host_virt || feat_dbg_ext))
            m = 32'hFFFF_FFFF;
        return m;
    endfunction

    function automatic logic req_match(input logic [31:0] w);
        if (!el2_present) return 1'b0;
        if (bp_type[3:2] == 2'b10) begin
            if (vmid16_supported && vmid_wide_sel) return w[15:0] == cur_vmid;
            return w[7:0] == cur_vmid[7:0];
        end
        if (bp_type[3:2] == 2'b11)
            return (feat_host_virt || feat_dbg_ext) && (w == cur_ctx2);
        return 1'b0;
    endfunction

    // Apply one cycle of stimulus and queue the expected post-edge outputs.
    task automatic step(input logic rst, input logic we, input logic [31:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n   = rst;
        wr_en   = we;
        wr_data = d;
        if (!rst) begin
            e.m = 1'b0;
            model_word = '0;
        end else begin
            e.m = req_match(model_word);
            if (we) model_word = d & req_mask();
        end
        e.rd  = model_word;
        e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk);
        #1;
    endtask

    // Monitor: compare outputs against the queued expectation.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (match_o !== e.m) begin
                fails++;
                $display("FAIL %s match_o actual=%0b expected=%0b", e.tag, match_o, e.m);
            end
            checks++;
            if (rd_data !== e.rd) begin
                fails++;
                $display("FAIL %s rd_data actual=%08h expected=%08h", e.tag, rd_data, e.rd);
            end
        end
    end

    initial begin
        // R1 reset state
        step(0, 0, 32'h0, "R1");
        step(0, 0, 32'h0, "R1");
        // R2 narrow VMID write; same cycle matches old word 0 (R10)
        bp_type = 4'b1000; cur_vmid = 16'h0000;
        step(1, 1, 32'hDEAD_BEEF, "R2 R10");
        cur_vmid = 16'h55EF; step(1, 0, 32'h0, "R6 hit");
        cur_vmid = 16'h55EE; step(1, 0, 32'h0, "R6 miss");
        // R3 wide VMID
        vmid16_supported = 1; vmid_wide_sel = 1; bp_type = 4'b1011;
        step(1, 1, 32'hCAFE_1234, "R3");
        cur_vmid = 16'h1234; step(1, 0, 32'h0, "R7 hit");
        cur_vmid = 16'h5534; step(1, 0, 32'h0, "R7 miss");
        vmid_wide_sel = 0;   step(1, 0, 32'h0, "R6 high byte ignored");
        vmid16_supported = 0; vmid_wide_sel = 1;
        step(1, 1, 32'hCAFE_1234, "R2 no 16-bit support");
        // R4 / R8 context
        bp_type = 4'b1100; feat_host_virt = 1;
        step(1, 1, 32'hA5A5_0F0F, "R4");
        cur_ctx2 = 32'hA5A5_0F0F; step(1, 0, 32'h0, "R8 hit");
        cur_ctx2 = 32'hA5A5_0F0E; step(1, 0, 32'h0, "R8 miss");
        cur_ctx2 = 32'hA5A5_0F0F; feat_host_virt = 0; feat_dbg_ext = 1;
        step(1, 0, 32'h0, "R8 alt feature");
        feat_dbg_ext = 0; step(1, 0, 32'h0, "R8 no feature");
        // R9 no EL2 / other types
        feat_host_virt = 1; el2_present = 0; step(1, 0, 32'h0, "R9 no el2");
        el2_present = 1; bp_type = 4'b0101; step(1, 0, 32'h0, "R9 other type");
        // R11 hold
        step(1, 0, 32'hFFFF_FFFF, "R11");
        // R5 reserved writes
        step(1, 1, 32'h1234_5678, "R5 other type");
        bp_type = 4'b1100; step(1, 1, 32'hFFFF_FFFF, "R4 refill");
        feat_host_virt = 0; step(1, 1, 32'h1357_9BDF, "R5 ctx no feature");
        bp_type = 4'b1001; el2_present = 0; step(1, 1, 32'h0000_00AB, "R5 no el2");
        // R10 same-cycle write and match
        el2_present = 1; step(1, 1, 32'h0000_0011, "R2 setup");
        cur_vmid = 16'h0022; step(1, 1, 32'h0000_0022, "R10 old word used");
        step(1, 0, 32'h0, "R10 new word used");
        // R1 reset mid-run
        bp_type = 4'b1100; feat_dbg_ext = 1; step(1, 1, 32'h8000_0001, "R4");
        step(0, 0, 32'h0, "R1 mid-run");
        step(1, 0, 32'h0, "R1 after");
        repeat (3) @(posedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #(5ns * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule